// File: doc/BRIEF.md
# Dual Latched Interval Timer Pair

This block holds two 16-bit down-counters. Each counter has its own 16-bit reload latch, and both sit behind a byte-wide register window with sixteen offsets. Counting advances only on cycles where a one-cycle tick enable is high, so the surrounding chip sets the count rate by how often it pulses that input. When a counter passes from zero to all ones, the block emits a one-cycle pulse for that timer toward an interrupt controller and sets a sticky flag.

The first timer can run in two ways. In free-running mode it counts the latch value down through zero and all ones, then reloads from the latch, so each period is latch+2 ticks. In one-shot mode it signals only the first underflow after a load and then keeps decrementing. The second timer is always one-shot and wraps modulo 2^16 with no reload. Software writes the low byte of a latch first. A write to the high byte then completes the value, and on the designated offsets that same write transfers the latch into the counter. Register reads are combinational and have no side effects.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both latches and both counters read 0xFFFF, the mode register at offset 0xB reads 0x00, and all pulses and flags are low.
- R2: A write to offset 0x4 or 0x6 replaces only the low byte of the first timer's latch. The first counter is left as it was, and the byte reads back at offset 0x6.
- R3: A write to offset 0x5 stores the first latch's high byte, loads the whole updated latch into the first counter, clears the first flag and re-arms the one-shot. If a tick arrives in the same cycle, the load wins: no decrement and no pulse.
- R4: A write to offset 0x7 stores the first latch's high byte and clears the first flag. The counter is not loaded.
- R5: Each counter decrements by one on every cycle where tickEn is high and holds otherwise, unless a load or reload applies.
- R6: A tick while a counter is at zero takes it to 0xFFFF. If that timer is allowed to signal, its pulse is high for exactly the following cycle and its flag sets. A flag set and a flag clear in the same cycle leave the flag set.
- R7: When bits 7:6 of the mode register are 01, a tick at 0xFFFF reloads the first counter from its latch. Pulses then repeat every latch+2 ticks.
- R8: With any other value in mode bits 7:6, the first timer pulses only on its first underflow after a load. It then keeps decrementing from 0xFFFF to 0xFFFE and onward, with no reload.
- R9: A write to offset 0x8 stores the second latch's low byte. A write to offset 0x9 stores its high byte, loads the whole latch into the second counter, clears the second flag and arms it. The second timer pulses once per load, never reloads, and does not pulse before its first load.
- R10: Reads return the first counter's low and high bytes at 0x4 and 0x5, the first latch's bytes at 0x6 and 0x7, the second counter's bytes at 0x8 and 0x9, and the mode register at 0xB. All other offsets read 0x00.
- R11: Writes to offsets other than 0x4 to 0x9 and 0xB change no readable state, pulse or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle count enable |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Combinational read byte at addr |
| t1Pulse | output | 1 | First timer underflow pulse |
| t2Pulse | output | 1 | Second timer underflow pulse |
| t1Flag | output | 1 | First timer sticky flag |
| t2Flag | output | 1 | Second timer sticky flag |

## Verification
The bench measures the free-running period directly by counting ticks between pulses. A design that reloaded at zero instead of after passing through all ones would show latch+1 ticks. It drives a load and a tick into the same cycle, where a design with the wrong priority would read back latch-1 or emit a spurious pulse. It also drives a flag clear into the same cycle as an underflow, where a design that let the clear win would lose the event. One-shot runs check that decrementing continues past 0xFFFF with no second pulse. Random register traffic with small latch values is compared cycle by cycle against a behavioural model in the bench.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int OFFSET_W = 4;

  localparam logic [OFFSET_W-1:0] OFF_T1_CNT_LO = 4'h4;
  localparam logic [OFFSET_W-1:0] OFF_T1_CNT_HI = 4'h5;
  localparam logic [OFFSET_W-1:0] OFF_T1_LAT_LO = 4'h6;
  localparam logic [OFFSET_W-1:0] OFF_T1_LAT_HI = 4'h7;
  localparam logic [OFFSET_W-1:0] OFF_T2_LO     = 4'h8;
  localparam logic [OFFSET_W-1:0] OFF_T2_HI     = 4'h9;
  localparam logic [OFFSET_W-1:0] OFF_MODE      = 4'hB;

  localparam logic [1:0] RUN_FREE = 2'b01;

  typedef struct packed {
    logic t1LatLo;
    logic t1LatHi;
    logic t1Load;
    logic t2LatLo;
    logic t2LatHi;   // also transfers latch to counter
    logic modeWr;
  } ditStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_C1LO, SEL_C1HI, SEL_L1LO, SEL_L1HI, SEL_C2LO, SEL_C2HI, SEL_MODE
  } ditRdSel_t;
endpackage

// File: rtl/dit_ctrl.sv
module dit_ctrl
  import dit_pkg::*;
(
  input  logic                wrEn,
  input  logic [OFFSET_W-1:0] addr,
  output ditStrobe_t          strb,
  output ditRdSel_t           rdSel
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (addr)
        OFF_T1_CNT_LO, OFF_T1_LAT_LO: strb.t1LatLo = 1'b1;
        OFF_T1_CNT_HI: begin
          strb.t1LatHi = 1'b1;
          strb.t1Load  = 1'b1;
        end
        OFF_T1_LAT_HI: strb.t1LatHi = 1'b1;
        OFF_T2_LO:     strb.t2LatLo = 1'b1;
        OFF_T2_HI:     strb.t2LatHi = 1'b1;
        OFF_MODE:      strb.modeWr  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFF_T1_CNT_LO: rdSel = SEL_C1LO;
      OFF_T1_CNT_HI: rdSel = SEL_C1HI;
      OFF_T1_LAT_LO: rdSel = SEL_L1LO;
      OFF_T1_LAT_HI: rdSel = SEL_L1HI;
      OFF_T2_LO:     rdSel = SEL_C2LO;
      OFF_T2_HI:     rdSel = SEL_C2HI;
      OFF_MODE:      rdSel = SEL_MODE;
      default:       rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dit_timer.sv
module dit_timer #(
  parameter int W              = 16,
  parameter bit RELOAD_CAPABLE = 1'b1,
  parameter bit ARM_AT_RESET   = 1'b1,
  localparam int HW            = W / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          wrLo,
  input  logic          wrHi,
  input  logic          doLoad,
  input  logic          reloadMode,
  input  logic [HW-1:0] wrData,
  output logic [W-1:0]  latch,
  output logic [W-1:0]  count,
  output logic          pulse,
  output logic          flag
);
  logic          armed;
  logic [W-1:0]  latchNext;
  logic          freeRun;
  logic          underflow;

  assign freeRun   = RELOAD_CAPABLE && reloadMode;
  assign latchNext = {wrHi ? wrData : latch[W-1:HW], wrLo ? wrData : latch[HW-1:0]};
  assign underflow = tickEn && !doLoad && (count == '0) && (armed || freeRun);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latch <= '1;
      count <= '1;
      armed <= ARM_AT_RESET;
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      latch <= latchNext;
      if (doLoad)
        count <= latchNext;
      else if (tickEn)
        count <= (freeRun && (count == '1)) ? latch : count - 1'b1;
      pulse <= underflow;
      if (doLoad)         armed <= 1'b1;
      else if (underflow) armed <= 1'b0;
      if (underflow)      flag <= 1'b1;
      else if (wrHi)      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dit_datapath.sv
module dit_datapath
  import dit_pkg::*;
#(
  parameter int W   = 16,
  localparam int HW = W / 2,
  localparam int NCH = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  ditStrobe_t    strb,
  input  ditRdSel_t     rdSel,
  input  logic [HW-1:0] wrData,
  output logic [HW-1:0] rdData,
  output logic          t1Pulse,
  output logic          t2Pulse,
  output logic          t1Flag,
  output logic          t2Flag,
  output logic [W-1:0]  t1Latch,
  output logic [W-1:0]  t2Latch,
  output logic [W-1:0]  t1Count,
  output logic [W-1:0]  t2Count,
  output logic [HW-1:0] modeReg
);
  logic [NCH-1:0] chLo, chHi, chLoad, chPulse, chFlag;
  logic [W-1:0]   chLatch [NCH];
  logic [W-1:0]   chCount [NCH];
  logic           freeRun;

  assign chLo    = {strb.t2LatLo, strb.t1LatLo};
  assign chHi    = {strb.t2LatHi, strb.t1LatHi};
  assign chLoad  = {strb.t2LatHi, strb.t1Load};
  assign freeRun = (modeReg[HW-1 -: 2] == RUN_FREE);

  always_ff @(posedge clk) begin
    if (!rstN)            modeReg <= '0;
    else if (strb.modeWr) modeReg <= wrData;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dit_timer #(
      .W(W),
      .RELOAD_CAPABLE(ch == 0),
      .ARM_AT_RESET(ch == 0)
    ) u_tmr (
      .clk(clk),
      .rstN(rstN),
      .tickEn(tickEn),
      .wrLo(chLo[ch]),
      .wrHi(chHi[ch]),
      .doLoad(chLoad[ch]),
      .reloadMode(freeRun),
      .wrData(wrData),
      .latch(chLatch[ch]),
      .count(chCount[ch]),
      .pulse(chPulse[ch]),
      .flag(chFlag[ch])
    );
  end

  assign t1Pulse = chPulse[0];
  assign t2Pulse = chPulse[1];
  assign t1Flag  = chFlag[0];
  assign t2Flag  = chFlag[1];
  assign t1Latch = chLatch[0];
  assign t2Latch = chLatch[1];
  assign t1Count = chCount[0];
  assign t2Count = chCount[1];

  always_comb begin
    case (rdSel)
      SEL_C1LO: rdData = t1Count[HW-1:0];
      SEL_C1HI: rdData = t1Count[W-1:HW];
      SEL_L1LO: rdData = t1Latch[HW-1:0];
      SEL_L1HI: rdData = t1Latch[W-1:HW];
      SEL_C2LO: rdData = t2Count[HW-1:0];
      SEL_C2HI: rdData = t2Count[W-1:HW];
      SEL_MODE: rdData = modeReg;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int DW   = CNT_W / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic [OFFSET_W-1:0] addr,
  input  logic [DW-1:0]       wrData,
  output logic [DW-1:0]       rdData,
  output logic                t1Pulse,
  output logic                t2Pulse,
  output logic                t1Flag,
  output logic                t2Flag
);
  ditStrobe_t       strb;
  ditRdSel_t        rdSel;
  logic [CNT_W-1:0] t1Latch, t2Latch, t1Count, t2Count;
  logic [DW-1:0]    modeReg;

  dit_ctrl u_ctrl (
    .wrEn(wrEn),
    .addr(addr),
    .strb(strb),
    .rdSel(rdSel)
  );

  dit_datapath #(.W(CNT_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .tickEn(tickEn),
    .strb(strb),
    .rdSel(rdSel),
    .wrData(wrData),
    .rdData(rdData),
    .t1Pulse(t1Pulse),
    .t2Pulse(t2Pulse),
    .t1Flag(t1Flag),
    .t2Flag(t2Flag),
    .t1Latch(t1Latch),
    .t2Latch(t2Latch),
    .t1Count(t1Count),
    .t2Count(t2Count),
    .modeReg(modeReg)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
#(
  parameter int W   = 16,
  localparam int HW = W / 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic                wrEn,
  input logic [OFFSET_W-1:0] addr,
  input logic [HW-1:0]       wrData,
  input logic                t1Pulse,
  input logic                t2Pulse,
  input logic                t1Flag,
  input logic                t2Flag,
  input logic [W-1:0]        t1Latch,
  input logic [W-1:0]        t2Latch,
  input logic [W-1:0]        t1Count,
  input logic [W-1:0]        t2Count,
  input logic [HW-1:0]       modeReg
);
  a_r3_load_transfer: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == OFF_T1_CNT_HI |=> t1Count == $past({wrData, t1Latch[HW-1:0]}));

  a_r2_latch_lo_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (addr == OFF_T1_CNT_LO || addr == OFF_T1_LAT_LO) && !tickEn |=> $stable(t1Count));

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !wrEn |=> $stable(t1Count) && $stable(t2Count));

  a_r6_t1_pulse_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    t1Pulse |-> t1Flag && t1Count == '1);

  a_r6_t2_pulse_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    t2Pulse |-> t2Flag && t2Count == '1);

  a_r7_reload_from_latch: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !wrEn && modeReg[HW-1 -: 2] == RUN_FREE && t1Count == '1
    |=> t1Count == $past(t1Latch));

  a_r9_t2_load_transfer: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == OFF_T2_HI |=> t2Count == $past({wrData, t2Latch[HW-1:0]}) && !t2Flag);

  a_r9_t2_decrement: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !(wrEn && addr == OFF_T2_HI) |=> t2Count == $past(t2Count) - 1'b1);
endmodule

bind dual_interval_timer dit_checker #(.W(CNT_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .tickEn(tickEn),
  .wrEn(wrEn),
  .addr(addr),
  .wrData(wrData),
  .t1Pulse(t1Pulse),
  .t2Pulse(t2Pulse),
  .t1Flag(t1Flag),
  .t2Flag(t2Flag),
  .t1Latch(t1Latch),
  .t2Latch(t2Latch),
  .t1Count(t1Count),
  .t2Count(t2Count),
  .modeReg(modeReg)
);

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       t1Pulse, t2Pulse, t1Flag, t2Flag;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [15:0] mL1, mC1, mL2, mC2;
  logic        mA1, mF1, mP1, mA2, mF2, mP2;
  logic [7:0]  mMode;

  dual_interval_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .t1Pulse(t1Pulse), .t2Pulse(t2Pulse),
    .t1Flag(t1Flag), .t2Flag(t2Flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mL1 = 16'hFFFF; mC1 = 16'hFFFF; mA1 = 1'b1; mF1 = 1'b0; mP1 = 1'b0;
    mL2 = 16'hFFFF; mC2 = 16'hFFFF; mA2 = 1'b0; mF2 = 1'b0; mP2 = 1'b0;
    mMode = 8'h00;
  endtask

  task automatic modelStep(logic we, logic [3:0] a, logic [7:0] d, logic tk);
    logic ld1, hi1, lo1, ld2, lo2, p1, p2, cont;
    logic [15:0] nl1, nl2;
    cont = (mMode[7:6] == 2'b01);
    ld1 = we && a == 4'h5;
    hi1 = we && (a == 4'h5 || a == 4'h7);
    lo1 = we && (a == 4'h4 || a == 4'h6);
    nl1 = {hi1 ? d : mL1[15:8], lo1 ? d : mL1[7:0]};
    p1  = tk && !ld1 && mC1 == 16'h0 && (mA1 || cont);
    if (ld1)     mC1 = nl1;
    else if (tk) mC1 = (cont && mC1 == 16'hFFFF) ? mL1 : mC1 - 16'd1;
    mA1 = ld1 ? 1'b1 : (p1 ? 1'b0 : mA1);
    mF1 = p1 ? 1'b1 : (hi1 ? 1'b0 : mF1);
    mP1 = p1;
    mL1 = nl1;
    ld2 = we && a == 4'h9;
    lo2 = we && a == 4'h8;
    nl2 = {ld2 ? d : mL2[15:8], lo2 ? d : mL2[7:0]};
    p2  = tk && !ld2 && mC2 == 16'h0 && mA2;
    if (ld2)     mC2 = nl2;
    else if (tk) mC2 = mC2 - 16'd1;
    mA2 = ld2 ? 1'b1 : (p2 ? 1'b0 : mA2);
    mF2 = p2 ? 1'b1 : (ld2 ? 1'b0 : mF2);
    mP2 = p2;
    mL2 = nl2;
    if (we && a == 4'hB) mMode = d;
  endtask

  function automatic logic [7:0] expRead(logic [3:0] a);
    case (a)
      4'h4: return mC1[7:0];
      4'h5: return mC1[15:8];
      4'h6: return mL1[7:0];
      4'h7: return mL1[15:8];
      4'h8: return mC2[7:0];
      4'h9: return mC2[15:8];
      4'hB: return mMode;
      default: return 8'h00;
    endcase
  endfunction

  // one clock cycle of stimulus, then compare pulses and flags
  task automatic step(logic we, logic [3:0] a, logic [7:0] d, logic tk, string req);
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; tickEn = tk;
    modelStep(we, a, d, tk);
    @(posedge clk);
    #1;
    wrEn = 1'b0; tickEn = 1'b0;
    check({req, " t1Pulse"}, {15'd0, t1Pulse}, {15'd0, mP1});
    check({req, " t2Pulse"}, {15'd0, t2Pulse}, {15'd0, mP2});
    check({req, " t1Flag"},  {15'd0, t1Flag},  {15'd0, mF1});
    check({req, " t2Flag"},  {15'd0, t2Flag},  {15'd0, mF2});
  endtask

  task automatic rdModel(logic [3:0] a, string req);
    wrEn = 1'b0; tickEn = 1'b0; addr = a;
    #1;
    check(req, {8'd0, rdData}, {8'd0, expRead(a)});
  endtask

  task automatic rdExp(logic [3:0] a, logic [7:0] v, string req);
    wrEn = 1'b0; tickEn = 1'b0; addr = a;
    #1;
    check(req, {8'd0, rdData}, {8'd0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int seen;
    int last;
    logic [7:0] keepLo;
    void'($urandom(32'd24680));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1 reset state
    for (int a = 4; a <= 9; a++) rdExp(4'(a), 8'hFF, "R1 reset byte");
    rdExp(4'hB, 8'h00, "R1 mode");
    check("R1 flags/pulses", {12'd0, t1Pulse, t2Pulse, t1Flag, t2Flag}, 16'd0);

    // R7 free-running period
    step(1, 4'hB, 8'h40, 0, "R7");
    step(1, 4'h6, 8'h03, 0, "R7");
    step(1, 4'h5, 8'h00, 0, "R7");
    rdExp(4'h4, 8'h03, "R3 loaded");
    seen = 0; last = -1;
    for (int i = 0; i < 30; i++) begin
      step(0, 4'h0, 8'h00, 1, "R7");
      if (t1Pulse) begin
        if (last >= 0) check("R7 period", 16'(i - last), 16'd5);
        last = i;
        seen++;
      end
    end
    check("R7 pulse count", 16'(seen), 16'd6);

    // R8 one-shot
    step(1, 4'hB, 8'h00, 0, "R8");
    step(1, 4'h4, 8'h02, 0, "R8");
    step(1, 4'h5, 8'h00, 0, "R8");
    seen = 0;
    for (int i = 0; i < 13; i++) begin
      step(0, 4'h0, 8'h00, 1, "R8");
      if (t1Pulse) seen++;
    end
    check("R8 single pulse", 16'(seen), 16'd1);
    rdExp(4'h4, 8'hF5, "R8 keeps counting lo");
    rdExp(4'h5, 8'hFF, "R8 keeps counting hi");

    // R2 latch low writes leave counter
    step(1, 4'h6, 8'h55, 0, "R2");
    rdExp(4'h6, 8'h55, "R2 latch lo");
    rdExp(4'h4, 8'hF5, "R2 count untouched");
    step(1, 4'h4, 8'h66, 0, "R2");
    rdExp(4'h6, 8'h66, "R2 latch lo alias");
    rdExp(4'h4, 8'hF5, "R2 count untouched alias");

    // R3 load wins over tick
    step(1, 4'hB, 8'h40, 0, "R3");
    step(1, 4'h6, 8'h07, 0, "R3");
    step(1, 4'h5, 8'h00, 1, "R3");
    rdExp(4'h4, 8'h07, "R3 load beats tick");

    // R6 set wins over clear
    step(1, 4'h6, 8'h01, 0, "R6");
    step(1, 4'h5, 8'h00, 0, "R6");
    step(0, 4'h0, 8'h00, 1, "R6");
    step(1, 4'h7, 8'h00, 1, "R6");
    check("R6 set beats clear", {15'd0, t1Flag}, 16'd1);
    check("R6 pulse", {15'd0, t1Pulse}, 16'd1);

    // R4 high latch write clears flag, keeps count
    step(1, 4'h7, 8'h12, 0, "R4");
    check("R4 flag cleared", {15'd0, t1Flag}, 16'd0);
    rdExp(4'h7, 8'h12, "R4 latch hi");
    rdExp(4'h4, 8'hFF, "R4 count lo kept");
    rdExp(4'h5, 8'hFF, "R4 count hi kept");
    step(1, 4'h7, 8'h00, 0, "R4");
    step(0, 4'h0, 8'h00, 1, "R7");
    rdExp(4'h4, 8'h01, "R7 reload value");

    // R3 load in the underflow cycle suppresses the pulse
    step(0, 4'h0, 8'h00, 1, "R5");
    step(1, 4'h5, 8'h00, 1, "R3");
    check("R3 no pulse on load", {15'd0, t1Pulse}, 16'd0);
    rdExp(4'h4, 8'h01, "R3 reloaded");

    // R9 second timer one-shot
    step(1, 4'h8, 8'h02, 0, "R9");
    step(1, 4'h9, 8'h00, 0, "R9");
    rdExp(4'h8, 8'h02, "R9 load");
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      step(0, 4'h0, 8'h00, 1, "R9");
      if (t2Pulse) seen++;
    end
    check("R9 single pulse", 16'(seen), 16'd1);
    rdExp(4'h8, 8'hFA, "R9 wrap lo");
    rdExp(4'h9, 8'hFF, "R9 wrap hi");

    // R11 unmapped writes ignored, R10 unmapped reads zero
    keepLo = expRead(4'h4);
    step(1, 4'h0, 8'hAA, 0, "R11");
    step(1, 4'hA, 8'hAA, 0, "R11");
    step(1, 4'hC, 8'hAA, 0, "R11");
    step(1, 4'hF, 8'hAA, 0, "R11");
    rdExp(4'h4, keepLo, "R11 count kept");
    for (int a = 0; a < 16; a++) rdModel(4'(a), "R10 map");

    // random traffic, R5 R6 R7 R8 R9 R10
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [3:0] a;
      logic [7:0] d;
      r = $urandom % 16;
      if (r < 11) begin
        step(0, 4'h0, 8'h00, 1, "R5 random");
      end else begin
        a = 4'($urandom % 16);
        if (a == 4'h5 || a == 4'h7 || a == 4'h9)
          d = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
        else if (a == 4'hB)
          d = 8'($urandom % 4) << 6;
        else
          d = 8'($urandom % 12);
        step(1, a, d, 1'($urandom % 2), "R6 random");
      end
      if (n % 8 == 0) rdModel(4'($urandom % 16), "R10 random read");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule